// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a short burst. When a load is pulsed, it registers a full start address. Each advance pulse after that moves an internal beat counter forward by one. The low bits of the output address are built from the registered start offset and the beat count. The upper bits come straight from the registered start address.

The beat order is chosen by a mode input. The mode is not registered: a change appears on the output in the same cycle and does not touch the counter. In linear order the offset counts upward from the start and wraps inside the group. In interleaved order the offset is the start offset XORed with the beat count. A burst may begin at any offset within its group of four. The address always comes back to the start after four beats and never carries into the upper bits.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low and after it is released, addr_o reads all zeros until the first load or advance.
- R2: One cycle after a clock edge with load_i high, addr_o equals the start_addr_i that was sampled at that edge. The beat count restarts at zero.
- R3: With mode_i = 0 (linear), the low two bits of addr_o equal the start offset plus the beat count, modulo 4.
- R4: With mode_i = 1 (interleaved), the low two bits of addr_o equal the start offset XOR the beat count.
- R5: Between loads, the upper bits of addr_o (bit 2 and above) never change, even when the start offset is 3.
- R6: After four advances, addr_o is back to the loaded start address in either mode.
- R7: At an edge where both load_i and adv_i are low, addr_o keeps its value, provided mode_i does not change.
- R8: When load_i and adv_i are high at the same edge, the load wins: addr_o equals the new start address with beat count zero.
- R9: A change of mode_i changes addr_o in the same cycle, with no clock edge. The beat count is kept, so switching back restores the earlier address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Register start address, clear beat count |
| adv_i | input | 1 | Step to next beat |
| mode_i | input | 1 | Order select: 0 linear, 1 interleaved |
| start_addr_i | input | ADDR_W | Start address of the burst |
| addr_o | output | ADDR_W | Address of the current beat |

## Verification
The hardest case to reach is a mode change in the middle of a burst. The count has to be non-zero, and the linear and interleaved orders must give different offsets at that count. The bench loads offset 1, advances once, and toggles mode_i between clock edges. It checks the output after each toggle, then advances again to show that the count was kept. Loads at offset 3 with all upper bits set test that the offset wraps without a carry into the upper bits.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] beat_q;

  // clear has priority over step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_q <= '0;
    else if (clear_i) beat_q <= '0;
    else if (step_i)  beat_q <= beat_q + 1'b1;
  end

  assign beat_o = beat_q;
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= addr_i;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] base_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  order_e            order_i,
  output logic [BEAT_W-1:0] ofs_o
);
  logic [BEAT_W-1:0] lin_ofs;
  logic [BEAT_W-1:0] ilv_ofs;

  // modulo add: the carry out of the top bit is dropped
  assign lin_ofs = base_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_ofs[b] = base_i[b] ^ beat_i[b];
  end

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVED: ofs_o = ilv_ofs;
      default:         ofs_o = lin_ofs;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] start_q;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] ofs;
  order_e            order;

  assign order = order_e'(mode_i);

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .addr_i (start_addr_i),
    .addr_o (start_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load_i),
    .step_i  (adv_i),
    .beat_o  (beat)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .base_i  (start_q[BEAT_W-1:0]),
    .beat_i  (beat),
    .order_i (order),
    .ofs_o   (ofs)
  );

  assign addr_o = {start_q[ADDR_W-1 -: UPPER_W], ofs};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              adv_i,
  input logic              mode_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] ref_start_q;
  logic [BEAT_W-1:0] ref_beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_start_q <= '0;
      ref_beat_q  <= '0;
    end else if (load_i) begin
      ref_start_q <= start_addr_i;
      ref_beat_q  <= '0;
    end else if (adv_i) begin
      ref_beat_q  <= ref_beat_q + 1'b1;
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk_i) !rst_ni |-> addr_o == '0); // R1
  AST_LOAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(start_addr_i)); // R2
  AST_LINEAR_OFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> addr_o[BEAT_W-1:0] == BEAT_W'(ref_start_q[BEAT_W-1:0] + ref_beat_q)); // R3
  AST_ILV_OFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> addr_o[BEAT_W-1:0] == (ref_start_q[BEAT_W-1:0] ^ ref_beat_q)); // R4
  AST_UPPER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])); // R5
  AST_WRAP_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_beat_q == '0 |-> addr_o == ref_start_q); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> (addr_o == $past(addr_o)) || (mode_i != $past(mode_i))); // R7
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .load_i       (load_i),
  .adv_i        (adv_i),
  .mode_i       (mode_i),
  .start_addr_i (start_addr_i),
  .addr_o       (addr_o)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic          adv_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [AW-1:0] addr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .adv_i(adv_i),
    .mode_i(mode_i), .start_addr_i(start_addr_i), .addr_o(addr_o)
  );

  task automatic check(string req, logic [AW-1:0] exp);
    n_chk++;
    if (addr_o !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] s, int n, logic m);
    logic [1:0] lo;
    lo = m ? (s[1:0] ^ 2'(n)) : 2'(s[1:0] + 2'(n));
    return {s[AW-1:2], lo};
  endfunction

  // drive at negedge, result visible one negedge later
  task automatic cyc(logic l, logic a, logic [AW-1:0] s);
    load_i = l; adv_i = a; start_addr_i = s;
    @(negedge clk_i);
    load_i = 1'b0; adv_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    start_addr_i = 20'hABCDE;
    repeat (3) @(negedge clk_i);
    check("R1 in reset", '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", '0);
  endtask

  task automatic t_burst(logic m, logic [AW-1:0] s);
    mode_i = m;
    cyc(1'b1, 1'b0, s);
    check("R2 load", s);
    for (int n = 1; n < 4; n++) begin
      cyc(1'b0, 1'b1, '0);
      check(m ? "R4 interleaved beat" : "R3 linear beat", beat_addr(s, n, m));
      check("R5 upper kept", {s[AW-1:2], addr_o[1:0]});
    end
    cyc(1'b0, 1'b1, '0);
    check("R6 wrap", s);
  endtask

  task automatic t_hold();
    mode_i = 1'b0;
    cyc(1'b1, 1'b0, 20'h12346);
    cyc(1'b0, 1'b1, '0);
    cyc(1'b0, 1'b0, 20'hFFFFF);
    cyc(1'b0, 1'b0, 20'h00000);
    check("R7 hold", 20'h12347);
  endtask

  task automatic t_priority();
    mode_i = 1'b0;
    cyc(1'b1, 1'b0, 20'h55550);
    cyc(1'b0, 1'b1, '0);
    cyc(1'b1, 1'b1, 20'hAAAA2);
    check("R8 load over advance", 20'hAAAA2);
  endtask

  task automatic t_mode_switch();
    mode_i = 1'b0;
    cyc(1'b1, 1'b0, 20'h0F0F1);
    cyc(1'b0, 1'b1, '0);
    check("R9 linear before switch", 20'h0F0F2);
    #1 mode_i = 1'b1; #1;
    check("R9 interleaved after switch", 20'h0F0F0);
    #1 mode_i = 1'b0; #1;
    check("R9 switch back", 20'h0F0F2);
    @(negedge clk_i);
    mode_i = 1'b1;
    cyc(1'b0, 1'b1, '0);
    check("R9 count kept", 20'h0F0F3);
  endtask

  initial begin
    t_reset();
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 4; o++) begin
        t_burst(1'(m), {18'h2B5C7 ^ 18'(o * 5), 2'(o)});
        t_burst(1'(m), {18'h3FFFF, 2'(o)});
      end
    t_hold();
    t_priority();
    t_mode_switch();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule